// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block is a pseudo-random stimulus source for built-in self-test. It holds a row of one-bit cells that all change on the same clock edge. Each cell's new value is formed from its two neighbours, and optionally from its own value. A per-cell select bit chooses between the two-input form (rule 90) and the three-input form (rule 150). Bits do not travel down the register as they do in a linear feedback shift register, so neighbouring output bits are far less correlated.

Software or a test controller writes a starting value, picks a rule vector and an edge treatment, and then enables stepping. With the edge cells tied to zero and a well-chosen rule vector, the register visits every nonzero state before it repeats. The all-zero state is a fixed point under every rule vector and either edge treatment. A flag reports that state so that the controller can reseed the register.

Top module: `ca_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes RESET_SEED (default: only cell 0 set, value 1) on that edge.
- R2: When `load_en` is high and `rst` is low, the state takes `seed` on the next edge, whatever `step_en` is.
- R3: When `rst`, `load_en` and `step_en` are all low, the state is unchanged across the edge.
- R4: When stepping, a cell whose `rule_sel` bit is 0 (rule 90) takes the XOR of its left neighbour (cell i-1) and its right neighbour (cell i+1). Its own value is not used.
- R5: When stepping, a cell whose `rule_sel` bit is 1 (rule 150) takes the XOR of its left neighbour, its own value and its right neighbour.
- R6: With `wrap_mode` = 0 (null edge), the left neighbour of cell 0 and the right neighbour of cell WIDTH-1 read as constant 0.
- R7: With `wrap_mode` = 1 (cyclic edge), the left neighbour of cell 0 is cell WIDTH-1, and the right neighbour of cell WIDTH-1 is cell 0.
- R8: `stuck` is high exactly when `state_q` is all zero. Stepping never clears it, and only a load with a nonzero seed or a reset does.
- R9: At WIDTH = 8 there exists a rule vector that, with a null edge and a seed of 1, returns to the seed after exactly 255 steps and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load `seed` into the cells; overrides stepping |
| seed | input | WIDTH | Starting value for the cells |
| step_en | input | 1 | Advance the automaton by one generation |
| rule_sel | input | WIDTH | Per-cell rule: 0 = rule 90, 1 = rule 150 |
| wrap_mode | input | 1 | 0 = null edge, 1 = cyclic edge |
| state_q | output | WIDTH | Current cell values, cell i on bit i |
| stuck | output | 1 | State is all zero |

## Verification
The cell values come from one register stage, so reset, load, hold and step each show on `state_q` at the first rising edge after the inputs are applied. `stuck` is decoded from that register and so follows in the same cycle. The bench drives its inputs on the falling edge, pushes the predicted state and flag into a queue at that moment, and pops and compares them 2 ns after the next rising edge. Every prediction is therefore checked against the first edge that could produce it. The period run compares all 255 generations this way, and the step that closes the cycle must bring the state back to the seed.

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] seed,
  input  logic             step_en,
  input  logic [WIDTH-1:0] rule_sel,
  input  logic             wrap_mode,
  output logic [WIDTH-1:0] state_q,
  output logic             stuck
);

  logic             lo_edge, hi_edge;
  logic [WIDTH+1:0] ext;
  logic [WIDTH-1:0] nxt;

  assign lo_edge = wrap_mode & state_q[WIDTH-1];
  assign hi_edge = wrap_mode & state_q[0];
  assign ext     = {hi_edge, state_q, lo_edge};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign nxt[i] = ext[i] ^ ext[i+2] ^ (rule_sel[i] & ext[i+1]);
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= RESET_SEED;
    else if (load_en) state_q <= seed;
    else if (step_en) state_q <= nxt;
  end

  assign stuck = ~|state_q;

endmodule

// File: rtl/ca_pattern_gen_chk.sv
module ca_pattern_gen_chk #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic [WIDTH-1:0] seed,
  input logic             step_en,
  input logic [WIDTH-1:0] state_q,
  input logic             stuck
);

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> state_q == RESET_SEED);

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> state_q == $past(seed));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_en) |=> $stable(state_q));

  assert_lockup_sticks_R8: assert property (@(posedge clk) disable iff (rst)
    (stuck && !load_en) |=> stuck);

  assert_reseed_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (load_en && seed != '0) |=> !stuck);

endmodule

bind ca_pattern_gen ca_pattern_gen_chk #(.WIDTH(WIDTH), .RESET_SEED(RESET_SEED)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .seed(seed),
  .step_en(step_en), .state_q(state_q), .stuck(stuck)
);

// File: tb/tb_ca_pattern_gen.sv
`timescale 1ns/1ps
module tb_ca_pattern_gen;
  localparam int W = 8;
  localparam logic [W-1:0] RST_VAL = 8'h01;

  logic clk = 1'b0;
  logic rst = 1'b0, load_en = 1'b0, step_en = 1'b0, wrap_mode = 1'b0;
  logic [W-1:0] seed = '0, rule_sel = '0;
  logic [W-1:0] state_q;
  logic stuck;

  always #4 clk = ~clk;

  ca_pattern_gen #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .seed(seed), .step_en(step_en),
    .rule_sel(rule_sel), .wrap_mode(wrap_mode), .state_q(state_q), .stuck(stuck)
  );

  typedef struct { logic [W:0] exp; string tag; } item_t;
  item_t sb[$];
  int vectors = 0, fails = 0;
  logic [W-1:0] mdl = '0;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [W-1:0] ref_next(logic [W-1:0] s, logic [W-1:0] r, logic cyc);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      logic l, rr;
      l  = (i == 0)     ? (cyc ? s[W-1] : 1'b0) : s[i-1];
      rr = (i == W - 1) ? (cyc ? s[0]   : 1'b0) : s[i+1];
      n[i] = r[i] ? (l ^ s[i] ^ rr) : (l ^ rr);
    end
    return n;
  endfunction

  task automatic apply(input logic r, input logic ld, input logic st,
                       input logic [W-1:0] sd, input logic [W-1:0] rl,
                       input logic cyc, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; load_en = ld; step_en = st; seed = sd; rule_sel = rl; wrap_mode = cyc;
    if (r)       mdl = RST_VAL;
    else if (ld) mdl = sd;
    else if (st) mdl = ref_next(mdl, rl, cyc);
    it.exp = {(mdl == '0), mdl};
    it.tag = tag;
    sb.push_back(it);
  endtask

  function automatic logic [W-1:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[23:16];
  endfunction

  initial begin
    forever begin
      item_t it;
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        vectors++;
        if ({stuck, state_q} !== it.exp) begin
          fails++;
          $display("FAIL %s: got stuck=%b state=%h, expected stuck=%b state=%h",
                   it.tag, stuck, state_q, it.exp[W], it.exp[W-1:0]);
        end
      end
    end
  end

  initial begin
    int cyc_cnt = 0;
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 20000) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cyc_cnt);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] best_rule;
    int best_ones, per;
    logic [W-1:0] s;
    logic [W-1:0] sd;

    // R1: reset value, also overriding load and step
    apply(1, 0, 0, '0, '0, 0, "R1 reset");
    apply(1, 1, 1, 8'hA5, 8'hFF, 0, "R1 reset over load");
    // R3: hold with random rule inputs
    apply(0, 0, 0, 8'h3C, 8'h5A, 1, "R3 hold");
    apply(0, 0, 0, 8'hC3, 8'hA5, 0, "R3 hold");
    // R2: load, including priority over step
    apply(0, 1, 0, 8'h96, 8'h00, 0, "R2 load");
    apply(0, 1, 1, 8'h4B, 8'hFF, 1, "R2 load over step");

    // R4 and R6: all rule 90, null edge
    apply(0, 1, 0, 8'h81, '0, 0, "R2 load");
    for (int k = 0; k < 6; k++) apply(0, 0, 1, '0, 8'h00, 0, "R4 R6 rule90 null");
    // R5 and R6: all rule 150, null edge
    apply(0, 1, 0, 8'h81, '0, 0, "R2 load");
    for (int k = 0; k < 6; k++) apply(0, 0, 1, '0, 8'hFF, 0, "R5 R6 rule150 null");
    // R7: cyclic edge, both rules
    apply(0, 1, 0, 8'h01, '0, 1, "R2 load");
    for (int k = 0; k < 6; k++) apply(0, 0, 1, '0, 8'h00, 1, "R4 R7 rule90 cyclic");
    apply(0, 1, 0, 8'h80, '0, 1, "R2 load");
    for (int k = 0; k < 6; k++) apply(0, 0, 1, '0, 8'hFF, 1, "R5 R7 rule150 cyclic");
    // mixed rules and edges, pseudo-random patterns
    for (int k = 0; k < 40; k++) begin
      if (k % 8 == 0) apply(0, 1, 0, rnd(), '0, 0, "R2 load");
      else apply(0, 0, (k % 5) != 0, '0, rnd(), k[1], "R4 R5 R6 R7 mixed");
    end

    // R8: lock-up from a zero seed, under both edges, then reseed
    apply(0, 1, 0, 8'h00, '0, 0, "R8 zero load");
    for (int k = 0; k < 3; k++) apply(0, 0, 1, '0, rnd(), k[0], "R8 stays stuck");
    apply(0, 1, 0, 8'h10, '0, 0, "R8 reseed clears");
    apply(0, 0, 1, '0, 8'h00, 0, "R8 running");

    // R9: exhaustive search for a maximal rule vector, fewest rule 150 cells
    best_rule = '0; best_ones = W + 1;
    for (int r = 0; r < (1 << W); r++) begin
      s = ref_next(8'h01, r[W-1:0], 1'b0);
      per = 1;
      while (s != 8'h01 && per < (1 << W)) begin
        s = ref_next(s, r[W-1:0], 1'b0);
        per++;
      end
      if (per == (1 << W) - 1 && $countones(r[W-1:0]) < best_ones) begin
        best_ones = $countones(r[W-1:0]);
        best_rule = r[W-1:0];
      end
    end
    vectors++;
    if (best_ones > W) begin
      fails++;
      $display("FAIL R9: got no maximal rule vector, expected one with period %0d", (1 << W) - 1);
    end
    sd = 8'h01;
    apply(0, 1, 0, sd, '0, 0, "R2 load");
    for (int k = 1; k <= (1 << W) - 1; k++) begin
      apply(0, 0, 1, '0, best_rule, 0, "R9 period walk");
      if (k < (1 << W) - 1 && mdl == sd) begin
        vectors++; fails++;
        $display("FAIL R9: got early return at step %0d, expected %0d", k, (1 << W) - 1);
      end
    end
    vectors++;
    if (mdl != sd) begin
      fails++;
      $display("FAIL R9: got %h after full period, expected %h", mdl, sd);
    end

    apply(0, 0, 0, '0, '0, 0, "R3 final hold");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule